// File: doc/BRIEF.md
# Quadrature Clock Divider with Duty Select

The block takes one fast clock running at eight times a base frequency F0 and derives three outputs from it: a signal at F0, a signal at twice F0, and a second signal at twice F0 that trails the first by a quarter of its period. A single phase counter drives all three outputs, and every output comes straight from a flip-flop. The three waveforms therefore share the same clock edges and have no relative skew or glitches.

A mode input selects between two output shapes. In square mode every output has a 50% duty cycle. In narrow mode every output is high for exactly one input clock per period. That gives 12.5% at F0 and 25% at twice F0. A request to change the mode is held back until the counter returns to its start position, so no pulse is ever cut short. Duty cycles finer than one input clock, such as 10%, cannot be made from this clock and are not offered.

Top module: `quad_clk_div`

## Requirements
- R1: While `rst` is high at a clock edge, all three outputs are low after that edge. The first clock edge with `rst` low drives `f0_out` and `i2_out` high together, and leaves `q2_out` low.
- R2: Outside reset, `f0_out` rises once every 8 clock cycles.
- R3: Outside reset, `i2_out` and `q2_out` each rise once every 4 clock cycles.
- R4: Every rising edge of `q2_out` comes exactly one clock after a rising edge of `i2_out`.
- R5: Every rising edge of `f0_out` falls on the same clock edge as a rising edge of `i2_out`.
- R6: In square mode (`narrow_mode` = 0), counting phase 0 as the cycle in which `f0_out` rises, the outputs are high in these phases: `f0_out` in phases 0–3, `i2_out` in phases 0, 1, 4 and 5, and `q2_out` in phases 1, 2, 5 and 6.
- R7: In narrow mode (`narrow_mode` = 1), `f0_out` is high only in phase 0, `i2_out` only in phases 0 and 4, and `q2_out` only in phases 1 and 5.
- R8: The block samples `narrow_mode` only at the clock edge that starts phase 0. A change at any other time has no effect on the outputs until the next phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock at 8·F0 |
| rst | input | 1 | Synchronous reset, active high |
| narrow_mode | input | 1 | 0 selects square outputs, 1 selects one-clock pulses |
| f0_out | output | 1 | Registered output at F0 |
| i2_out | output | 1 | Registered in-phase output at 2·F0 |
| q2_out | output | 1 | Registered quadrature output at 2·F0, lagging by one clock |

## Verification
Each output changes on the clock edge that follows the inputs it depends on, because only one register stage lies between the counter and the pins. The bench drives reset and mode at the falling edge. It queues one expected triple for the next rising edge, and it compares that triple one nanosecond after the edge. A mode change becomes visible only from the next phase 0, which may be up to eight edges later. The bench model therefore holds the requested mode until the wrap, as R8 requires. It also checks edge spacing and lag by counting sampled cycles between observed rising edges.

// File: rtl/qd_pkg.sv
package qd_pkg;
  // Bundle of the three divider outputs.
  typedef struct packed {
    logic f0;
    logic i2;
    logic q2;
  } qd_wave_t;

  // Output shape selection.
  typedef enum logic {
    SHAPE_SQUARE = 1'b0,
    SHAPE_NARROW = 1'b1
  } qd_shape_e;
endpackage

// File: rtl/qd_phase_ctr.sv
// Free-running phase counter; resets to all ones so the first active edge yields phase 0.
module qd_phase_ctr #(
  parameter int PHASE_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  output logic [PHASE_W-1:0] phase_nxt,
  output logic               wrap_nxt
);
  logic [PHASE_W-1:0] phase_q;

  assign phase_nxt = phase_q + 1'b1;
  assign wrap_nxt  = (phase_nxt == '0);

  always_ff @(posedge clk) begin
    if (rst) phase_q <= '1;
    else     phase_q <= phase_nxt;
  end
endmodule

// File: rtl/qd_mode_gate.sv
// Holds the active shape; a new request is accepted only on the edge that starts phase 0.
module qd_mode_gate
  import qd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      req_narrow,
  input  logic      wrap_nxt,
  output qd_shape_e shape_nxt
);
  qd_shape_e shape_q;

  always_comb begin
    if (wrap_nxt) shape_nxt = req_narrow ? SHAPE_NARROW : SHAPE_SQUARE;
    else          shape_nxt = shape_q;
  end

  always_ff @(posedge clk) begin
    if (rst) shape_q <= SHAPE_SQUARE;
    else     shape_q <= shape_nxt;
  end
endmodule

// File: rtl/qd_wave_decode.sv
// Maps a phase value to the three output levels for the selected shape.
module qd_wave_decode
  import qd_pkg::*;
#(
  parameter int PHASE_W = 3
) (
  input  logic [PHASE_W-1:0] phase,
  input  qd_shape_e          shape,
  output qd_wave_t           wave
);
  // Quarter period of the 2x output, in input clocks.
  localparam int LAG = 2 ** (PHASE_W - 3);
  localparam logic [PHASE_W-1:0] LAG_V = PHASE_W'(LAG);

  logic [PHASE_W-1:0] qphase;
  assign qphase = phase - LAG_V;

  generate
    if (PHASE_W < 3) begin : g_bad
      assign wave = '0;
    end else begin : g_ok
      always_comb begin
        if (shape == SHAPE_NARROW) begin
          wave.f0 = (phase == '0);
          wave.i2 = (phase[PHASE_W-2:0] == '0);
          wave.q2 = (qphase[PHASE_W-2:0] == '0);
        end else begin
          wave.f0 = ~phase[PHASE_W-1];
          wave.i2 = ~phase[PHASE_W-2];
          wave.q2 = ~qphase[PHASE_W-2];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/quad_clk_div.sv
// Top: counter, mode gate and decoder feed one output register stage.
module quad_clk_div
  import qd_pkg::*;
#(
  parameter int PHASE_W = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic narrow_mode,
  output logic f0_out,
  output logic i2_out,
  output logic q2_out
);
  logic [PHASE_W-1:0] phase_nxt;
  logic               wrap_nxt;
  qd_shape_e          shape_nxt;
  qd_wave_t           wave_nxt;
  qd_wave_t           wave_q;

  qd_phase_ctr #(.PHASE_W(PHASE_W)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .phase_nxt (phase_nxt),
    .wrap_nxt  (wrap_nxt)
  );

  qd_mode_gate u_gate (
    .clk        (clk),
    .rst        (rst),
    .req_narrow (narrow_mode),
    .wrap_nxt   (wrap_nxt),
    .shape_nxt  (shape_nxt)
  );

  qd_wave_decode #(.PHASE_W(PHASE_W)) u_dec (
    .phase (phase_nxt),
    .shape (shape_nxt),
    .wave  (wave_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) wave_q <= '0;
    else     wave_q <= wave_nxt;
  end

  assign f0_out = wave_q.f0;
  assign i2_out = wave_q.i2;
  assign q2_out = wave_q.q2;
endmodule

// File: rtl/qd_checker.sv
// Port-level properties for quad_clk_div, attached by bind.
module qd_checker (
  input logic clk,
  input logic rst,
  input logic narrow_mode,
  input logic f0_out,
  input logic i2_out,
  input logic q2_out
);
  // Cycles since reset release, saturating; guards the $past windows.
  logic [3:0] run_cyc;
  always_ff @(posedge clk) begin
    if (rst)                run_cyc <= '0;
    else if (run_cyc != 4'hF) run_cyc <= run_cyc + 1'b1;
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!f0_out && !i2_out && !q2_out));

  a_r2_f0_period: assert property (@(posedge clk) disable iff (rst)
    (run_cyc >= 4'd12 && $rose(f0_out)) |-> $past(f0_out, 8));

  a_r3_i2_period: assert property (@(posedge clk) disable iff (rst)
    (run_cyc >= 4'd8 && $rose(i2_out)) |-> $past(i2_out, 4));

  a_r4_quad_lag: assert property (@(posedge clk) disable iff (rst)
    $rose(i2_out) |=> $rose(q2_out));

  a_r5_f0_with_i2: assert property (@(posedge clk) disable iff (rst)
    $rose(f0_out) |-> $rose(i2_out));

  a_r7_no_overlap_narrow: assert property (@(posedge clk) disable iff (rst)
    (f0_out && !i2_out) |-> !$rose(f0_out));
endmodule

bind quad_clk_div qd_checker i_qd_checker (.*);

// File: tb/test_quad_clk_div.sv
module test_quad_clk_div;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic narrow_mode = 1'b0;
  logic f0_out, i2_out, q2_out;

  always #2 clk = ~clk;

  quad_clk_div i_quad_clk_div (
    .clk         (clk),
    .rst         (rst),
    .narrow_mode (narrow_mode),
    .f0_out      (f0_out),
    .i2_out      (i2_out),
    .q2_out      (q2_out)
  );

  typedef struct {
    logic [2:0] exp;
    string      tag;
  } item_t;

  item_t sb_q[$];
  int total = 0;
  int bad = 0;
  bit done = 0;

  // Reference model state, derived from the requirements.
  int  m_ph = 7;
  bit  m_act = 0;

  function automatic logic [2:0] shape_of(int ph, bit nar);
    logic f, i, q;
    if (nar) begin
      f = (ph == 0); i = (ph == 0 || ph == 4); q = (ph == 1 || ph == 5);   // R7
    end else begin
      f = (ph <= 3); i = (ph % 4 <= 1); q = (ph % 4 == 1 || ph % 4 == 2); // R6
    end
    return {f, i, q};
  endfunction

  task automatic step(input bit r, input bit m);
    item_t it;
    @(negedge clk);
    rst = r;
    narrow_mode = m;
    if (r) begin
      m_ph = 7; m_act = 0;
      it.exp = 3'b000; it.tag = "R1";
    end else begin
      m_ph = (m_ph + 1) % 8;
      if (m_ph == 0) m_act = m;          // R8: sampled only at phase 0
      it.exp = shape_of(m_ph, m_act);
      if (m != m_act)  it.tag = "R8";
      else if (m_act)  it.tag = "R7";
      else             it.tag = "R6";
    end
    sb_q.push_back(it);
  endtask

  task automatic run(input int n, input bit m);
    for (int k = 0; k < n; k++) step(0, m);
  endtask

  // Monitor: compares values and edge spacing.
  int cyc = 0;
  int last_f0 = -1, last_i2 = -1, last_q2 = -1;
  logic p_f0 = 0, p_i2 = 0, p_q2 = 0;

  initial begin
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        total++;
        if ({f0_out, i2_out, q2_out} !== it.exp) begin
          bad++;
          $display("FAIL %s: outputs f0/i2/q2=%b expected %b at cycle %0d",
                   it.tag, {f0_out, i2_out, q2_out}, it.exp, cyc);
        end
      end
      if (rst) begin
        last_f0 = -1; last_i2 = -1; last_q2 = -1;
      end else begin
        if (f0_out && !p_f0) begin
          total++;  // R5
          if (!(i2_out && !p_i2)) begin
            bad++; $display("FAIL R5: i2 rise=%0d expected 1 with f0 rise", i2_out && !p_i2);
          end
          if (last_f0 >= 0) begin
            total++;  // R2
            if (cyc - last_f0 != 8) begin
              bad++; $display("FAIL R2: f0 period=%0d expected 8", cyc - last_f0);
            end
          end
          last_f0 = cyc;
        end
        if (i2_out && !p_i2) begin
          if (last_i2 >= 0) begin
            total++;  // R3
            if (cyc - last_i2 != 4) begin
              bad++; $display("FAIL R3: i2 period=%0d expected 4", cyc - last_i2);
            end
          end
          last_i2 = cyc;
        end
        if (q2_out && !p_q2) begin
          total++;  // R4
          if (cyc - last_i2 != 1) begin
            bad++; $display("FAIL R4: q2 lag=%0d expected 1", cyc - last_i2);
          end
          if (last_q2 >= 0) begin
            total++;  // R3
            if (cyc - last_q2 != 4) begin
              bad++; $display("FAIL R3: q2 period=%0d expected 4", cyc - last_q2);
            end
          end
          last_q2 = cyc;
        end
      end
      p_f0 = f0_out; p_i2 = i2_out; p_q2 = q2_out;
    end
  end

  // Driver.
  initial begin
    for (int k = 0; k < 3; k++) step(1, 0);   // R1 reset state
    run(24, 0);                                // R6 square
    run(3, 0);
    run(21, 1);                                // R8 request mid-period, then R7
    run(5, 1);
    run(14, 0);                                // R8 back to square
    for (int k = 0; k < 2; k++) step(1, 1);   // R1 reset mid-run
    run(20, 1);                                // R7 from reset
    for (int k = 0; k < 14; k++) run(3, k % 2); // R8 toggling
    run(16, 0);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: done=0 expected 1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule